// File: doc/BRIEF.md
# Control-Bit Composed Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit for two signed two's-complement operands. There is no opcode. Six independent control bits each switch one stage of the datapath. Each operand can first be cleared and then bitwise complemented. The core either adds the two conditioned operands or takes their bitwise AND. The chosen core result can then be complemented before it leaves the block. Stacking these stages gives the whole set of functions: add, subtract, increment, decrement, negate, AND, OR (through De Morgan) and the constants 0, 1 and -1.

Beside the result word, the block reports two flags. One is high when the result is zero and one is high when the result is negative. The block also exposes every carry of its ripple adder, so that a user can watch the carry chain. The carry into the lowest bit is tied to zero. The carry out of the top bit is made visible but does not enter the result, and no overflow flag is produced. The operand width is a parameter with a default of 3 bits.

Top module: `bitctl_alu`

## Requirements
- R1: When zero_x is 1 the X path becomes all zeros before any further stage, and when zero_y is 1 the Y path does the same; when the bit is 0 the operand passes unchanged.
- R2: inv_x and inv_y bitwise-complement their operand after the optional clearing, so setting both the clear bit and the complement bit of one operand gives all ones for that operand.
- R3: With sel_add at 0 the core result is the bitwise AND of the two conditioned operands.
- R4: With sel_add at 1 the core result is the sum of the two conditioned operands modulo 2^W, with a carry-in of 0.
- R5: With inv_out at 1 the selected core result is bitwise complemented before it reaches res_o; with inv_out at 0 it passes unchanged.
- R6: zero_o is 1 exactly when res_o is all zeros.
- R7: neg_o is 1 exactly when bit W-1 of res_o is 1.
- R8: carry_o[i] is the carry into bit i of the adder for the conditioned operands: carry_o[0] is always 0, and carry_o[W] is the carry out of the top bit, which does not appear in res_o. The carries are driven whatever the value of sel_add.
- R9: All outputs depend only on the present inputs, with no clock, no reset and no stored state.
- R10: With every control bit at 0 except sel_add at 1, adding X = 011 and Y = 001 at W = 3 wraps to res_o = 100, with neg_o = 1 and zero_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W | Operand X, two's complement |
| y_i | input | W | Operand Y, two's complement |
| zero_x | input | 1 | Clear the X path |
| inv_x | input | 1 | Complement the X path after clearing |
| zero_y | input | 1 | Clear the Y path |
| inv_y | input | 1 | Complement the Y path after clearing |
| sel_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Complement the selected result |
| res_o | output | W | Result word |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result's top bit is set |
| carry_o | output | W+1 | Ripple carries, index i is the carry into bit i |

## Verification
Whenever the inputs change, the bound checker tests a set of invariants. The two flags must never be high together. The lowest carry must stay at zero. Clearing and complementing must force the constant operands they imply. A plain add must match the integer sum and its final carry. Only the bench's sweep can show that every combination of the six control bits, applied to every operand pair, gives the right word, flags and intermediate carries. The bench compares each of these against its own integer model, and it also walks through the named wraparound case.

// File: rtl/bitctl_alu.sv
module bitctl_alu #(
  parameter int W = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         zero_x,
  input  logic         inv_x,
  input  logic         zero_y,
  input  logic         inv_y,
  input  logic         sel_add,
  input  logic         inv_out,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic [W:0]   carry_o
);
  logic [W-1:0] xa, ya, xc, yc, sum, core;
  logic [W:0]   cy;

  assign xa = zero_x ? '0 : x_i;
  assign ya = zero_y ? '0 : y_i;
  assign xc = inv_x ? ~xa : xa;
  assign yc = inv_y ? ~ya : ya;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_rip
    assign sum[i]  = xc[i] ^ yc[i] ^ cy[i];
    assign cy[i+1] = (xc[i] & yc[i]) | (cy[i] & (xc[i] ^ yc[i]));
  end

  assign core    = sel_add ? sum : (xc & yc);
  assign res_o   = inv_out ? ~core : core;
  assign zero_o  = ~|res_o;
  assign neg_o   = res_o[W-1];
  assign carry_o = cy;
endmodule

module bitctl_alu_chk #(
  parameter int W = 3
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic         zero_x,
  input logic         inv_x,
  input logic         zero_y,
  input logic         inv_y,
  input logic         sel_add,
  input logic         inv_out,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic [W:0]   carry_o
);
  logic [W:0] plain;
  assign plain = {1'b0, x_i} + {1'b0, y_i};

  always_comb begin
    assert_flags_exclusive_R6: assert (!(zero_o && neg_o));
    assert_carry_base_R8: assert (carry_o[0] == 1'b0);
    if (zero_x && !inv_x && !sel_add && !inv_out)
      assert_cleared_and_R1: assert (res_o == '0 && zero_o);
    if (zero_x && inv_x && zero_y && inv_y && !sel_add && !inv_out)
      assert_ones_operands_R2: assert (&res_o && neg_o);
    if (sel_add && !zero_x && !inv_x && !zero_y && !inv_y && !inv_out)
      assert_plain_sum_R4: assert (res_o == plain[W-1:0] && carry_o[W] == plain[W]);
    if (sel_add && inv_out && zero_x && zero_y && !inv_x && !inv_y)
      assert_inverted_zero_R5: assert (&res_o);
  end
endmodule

bind bitctl_alu bitctl_alu_chk #(.W(W)) u_chk (
  .x_i(x_i), .y_i(y_i), .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y),
  .inv_y(inv_y), .sel_add(sel_add), .inv_out(inv_out), .res_o(res_o),
  .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o)
);

// File: tb/bitctl_alu_bench.sv
module bitctl_alu_bench;
  localparam int W = 3;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] x_i = '0, y_i = '0;
  logic zero_x = 0, inv_x = 0, zero_y = 0, inv_y = 0, sel_add = 0, inv_out = 0;
  logic [W-1:0] res_o;
  logic zero_o, neg_o;
  logic [W:0] carry_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  bitctl_alu #(.W(W)) u_bitctl_alu (
    .x_i(x_i), .y_i(y_i), .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y),
    .inv_y(inv_y), .sel_add(sel_add), .inv_out(inv_out), .res_o(res_o),
    .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d ctl=%b%b%b%b%b%b)",
               req, act, exp, x_i, y_i, zero_x, inv_x, zero_y, inv_y, sel_add, inv_out);
    end
  endtask

  task automatic apply(input int x, input int y, input int ctl);
    @(posedge clk);
    x_i = x[W-1:0]; y_i = y[W-1:0];
    {zero_x, inv_x, zero_y, inv_y, sel_add, inv_out} = ctl[5:0];
    @(negedge clk);
  endtask

  task automatic compare();
    int xc, yc, core, res;
    string rq;
    xc = zero_x ? 0 : int'(x_i);
    if (inv_x) xc = ~xc & M;
    yc = zero_y ? 0 : int'(y_i);
    if (inv_y) yc = ~yc & M;
    core = sel_add ? ((xc + yc) & M) : (xc & yc);
    res = inv_out ? (~core & M) : core;
    rq = sel_add ? (inv_out ? "R4/R5 sum" : "R4 sum") : (inv_out ? "R3/R5 and" : "R3 and");
    if (zero_x || zero_y || inv_x || inv_y) rq = {rq, " R1/R2 cond"};
    check(rq, int'(res_o), res);
    check("R6 zero flag", int'(zero_o), int'(res == 0));
    check("R7 neg flag", int'(neg_o), (res >> (W-1)) & 1);
    for (int i = 0; i <= W; i++) begin
      int lowmask = (1 << i) - 1;
      check($sformatf("R8 carry[%0d]", i), int'(carry_o[i]),
            (((xc & lowmask) + (yc & lowmask)) >> i) & 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: all-zero inputs give AND of zeros with no stored state
    check("R9 idle result", int'(res_o), 0);
    check("R9 idle zero flag", int'(zero_o), 1);
    check("R9 idle carries", int'(carry_o), 0);
    // R10: wraparound case
    apply(3, 1, 6'b000010);
    check("R10 wrap result", int'(res_o), 4);
    check("R10 wrap neg", int'(neg_o), 1);
    check("R10 wrap zero", int'(zero_o), 0);
    check("R10 carry out", int'(carry_o[W]), 0);
    // R2: clear then complement gives all ones regardless of operand
    apply(5, 2, 6'b110010);
    check("R2 ones plus y", int'(res_o), 1);
    // full sweep
    for (int c = 0; c < 64; c++)
      for (int x = 0; x <= M; x++)
        for (int y = 0; y <= M; y++) begin
          apply(x, y, c);
          compare();
        end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule